// File: doc/BRIEF.md
# Cyclic All-Reduce Summation Unit

This block takes a vector of integer lanes and leaves the sum of all of them in every lane. It accepts one vector at a time over a valid/ready handshake, then runs one round per clock. In each round every lane adds the value of a partner lane to its own value. The partner lies a fixed stride away, and the index wraps around the lane count. The stride begins at half the lane count and halves each round, so after log2(LANES) rounds every lane holds the same total.

The input side follows valid/ready rules. A vector transfers on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` drops for the whole reduction, and any `in_valid` presented during that time is ignored and has no effect. The output side has no back-pressure. `out_valid` is a one-cycle flag, and the lane registers are always visible on `out_data`. After the flag the lanes keep their values until the next vector is accepted, so a consumer may sample them late. A new vector may be accepted in the same cycle that `out_valid` is high.

Top module: `allreduce_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and every lane of `out_data` is 0.
- R2: On a clock edge where `in_valid` and `in_ready` are both high, lane i (bits i*WIDTH upward) is loaded with element i of `in_data`. The loaded vector appears on `out_data` after that edge.
- R3: From the accepting edge until the cycle in which `out_valid` is high, `in_ready` is 0. `in_valid` and `in_data` applied in that window are ignored and leave the result unchanged.
- R4: In a round with stride d, lane i takes its own value plus the value of lane (i+d) mod LANES, using values from before the round. The first round uses d = LANES/2.
- R5: `out_valid` is high for exactly one cycle, log2(LANES) clock edges after the accepting edge, and is low in between.
- R6: When `out_valid` is high, every lane equals the sum of all loaded elements.
- R7: While idle with no transfer, the lanes hold their values, and `out_valid` stays low.
- R8: Sums wrap modulo 2^WIDTH with no saturation or overflow indication.
- R9: A vector offered while `out_valid` is high is accepted on that edge, and its reduction proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector offered |
| in_ready | output | 1 | Unit can accept a vector |
| in_data | input | LANES*WIDTH | Packed input lanes, lane 0 in the low bits |
| out_valid | output | 1 | One-cycle flag: reduction complete |
| out_data | output | LANES*WIDTH | Packed lane registers, lane 0 in the low bits |

## Verification
A wrong partner index or a wrong stride corrupts the lanes on the first round. The bench checks the vector after the first round, so that fault shows one cycle after the load. A round counter that stops early or late moves `out_valid` away from its fixed cycle, and the final check against the arithmetic total catches it in the same cycle. A reload while busy, or lanes that drift while idle, change `out_data` at the next edge. The bench checks that edge in every run.

// File: rtl/allreduce_pkg.sv
package allreduce_pkg;
  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_RUN  = 2'd1,
    CTL_DONE = 2'd2
  } ctl_state_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/allreduce_seq.sv
module allreduce_seq
  import allreduce_pkg::*;
#(
  parameter int unsigned ROUNDS = 3,
  parameter int unsigned RIW    = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  output logic           load,
  output logic           step,
  output logic [RIW-1:0] round_idx,
  output logic           done
);
  localparam logic [RIW-1:0] LAST = RIW'(ROUNDS - 1);

  ctl_state_e state_q;
  logic [RIW-1:0] rnd_q;

  assign in_ready  = (state_q != CTL_RUN);
  assign load      = in_valid && in_ready;
  assign step      = (state_q == CTL_RUN);
  assign done      = (state_q == CTL_DONE);
  assign round_idx = rnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CTL_IDLE;
      rnd_q   <= '0;
    end else begin
      case (state_q)
        CTL_RUN: begin
          if (rnd_q == LAST) begin
            state_q <= CTL_DONE;
            rnd_q   <= '0;
          end else begin
            rnd_q <= rnd_q + 1'b1;
          end
        end
        default: begin
          rnd_q   <= '0;
          state_q <= load ? CTL_RUN : CTL_IDLE;
        end
      endcase
    end
  end

  // R5
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !in_ready);
  // R5
  round_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (round_idx <= LAST));
  // R5
  finish_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && round_idx == LAST) |=> done);
endmodule

// File: rtl/allreduce_lanes.sv
module allreduce_lanes #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ROUNDS = 3,
  parameter int unsigned RIW    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   step,
  input  logic [RIW-1:0]         round_idx,
  input  logic [LANES*WIDTH-1:0] load_data,
  output logic [LANES*WIDTH-1:0] lane_q
);
  logic [WIDTH-1:0] q       [LANES];
  logic [WIDTH-1:0] partner [LANES];
  logic [WIDTH-1:0] cand    [LANES][ROUNDS];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    for (genvar r = 0; r < ROUNDS; r++) begin : g_round
      assign cand[i][r] = q[(i + (LANES >> (r + 1))) % LANES];
    end

    always_comb begin
      partner[i] = cand[i][0];
      for (int r = 1; r < ROUNDS; r++) begin
        if (round_idx == RIW'(r)) partner[i] = cand[i][r];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q[i] <= '0;
      else if (load) q[i] <= load_data[i*WIDTH +: WIDTH];
      else if (step) q[i] <= q[i] + partner[i];
    end

    assign lane_q[i*WIDTH +: WIDTH] = q[i];
  end

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (lane_q == $past(load_data)));
  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(lane_q));
endmodule

// File: rtl/allreduce_unit.sv
module allreduce_unit
  import allreduce_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned WIDTH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*WIDTH-1:0] in_data,
  output logic                   out_valid,
  output logic [LANES*WIDTH-1:0] out_data
);
  localparam int unsigned ROUNDS = $clog2(LANES);
  localparam int unsigned RIW    = idx_width(ROUNDS);

  logic           load;
  logic           step;
  logic [RIW-1:0] round_idx;
  logic           lanes_agree;

  allreduce_seq #(.ROUNDS(ROUNDS), .RIW(RIW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .load      (load),
    .step      (step),
    .round_idx (round_idx),
    .done      (out_valid)
  );

  allreduce_lanes #(.LANES(LANES), .WIDTH(WIDTH), .ROUNDS(ROUNDS), .RIW(RIW)) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .round_idx (round_idx),
    .load_data (in_data),
    .lane_q    (out_data)
  );

  always_comb begin
    lanes_agree = 1'b1;
    for (int i = 1; i < LANES; i++) begin
      if (out_data[i*WIDTH +: WIDTH] != out_data[WIDTH-1:0]) lanes_agree = 1'b0;
    end
  end

  initial begin
    lanes_pow2_chk: assert ((LANES >= 2) && ((LANES & (LANES - 1)) == 0));
  end

  // R6
  lanes_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> lanes_agree);
endmodule

// File: tb/test_allreduce_unit.sv
module test_allreduce_unit;
  localparam int L = 8;
  localparam int W = 8;
  localparam int R = $clog2(L);
  localparam int N = L * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N-1:0] in_data = '0;
  logic out_valid;
  logic [N-1:0] out_data;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  allreduce_unit #(.LANES(L), .WIDTH(W)) i_allreduce_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] first_round(input logic [N-1:0] v);
    logic [N-1:0] e;
    for (int i = 0; i < L; i++)
      e[i*W +: W] = v[i*W +: W] + v[((i + L/2) % L)*W +: W];
    return e;
  endfunction

  function automatic logic [N-1:0] total_vec(input logic [N-1:0] v);
    logic [W-1:0] s = '0;
    logic [N-1:0] e;
    for (int i = 0; i < L; i++) s = s + v[i*W +: W];
    for (int i = 0; i < L; i++) e[i*W +: W] = s;
    return e;
  endfunction

  // Called at a negedge just after the accepting edge; runs to the done cycle.
  task automatic finish_run(input logic [N-1:0] v, input bit poke, input string tag);
    check(out_data == v, {"R2 load ", tag}, out_data, v);
    check(in_ready == 1'b0, {"R3 ready low ", tag}, N'(in_ready), '0);
    if (poke) begin in_valid = 1'b1; in_data = ~v; end
    else in_valid = 1'b0;
    if (R == 2) in_valid = 1'b0;
    @(negedge clk);
    check(out_data == first_round(v), {"R4 first round ", tag}, out_data, first_round(v));
    for (int r = 2; r <= R; r++) begin
      check(out_valid == 1'b0, {"R5 early done ", tag}, N'(out_valid), '0);
      if (r == R - 1) in_valid = 1'b0;
      @(negedge clk);
    end
    check(out_valid == 1'b1, {"R5 done ", tag}, N'(out_valid), N'(1));
    check(out_data == total_vec(v), {"R6 total ", tag}, out_data, total_vec(v));
  endtask

  task automatic run(input logic [N-1:0] v, input bit poke, input string tag);
    in_valid = 1'b1;
    in_data  = v;
    @(negedge clk);
    finish_run(v, poke, tag);
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == total_vec(v), {"R7 hold ", tag}, out_data, total_vec(v));
    check(in_ready == 1'b1, {"R7 ready ", tag}, N'(in_ready), N'(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] lf;
    logic [N-1:0] v;
    repeat (3) @(negedge clk);
    // R1
    check(out_valid == 1'b0 && in_ready == 1'b1 && out_data == '0, "R1 reset", out_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, "R1 after release", out_data, '0);

    // one-hot lane patterns
    for (int i = 0; i < L; i++) begin
      v = '0; v[i*W +: W] = 8'h01; run(v, 1'b0, "onehot1");
      v = '0; v[i*W +: W] = 8'h80; run(v, 1'b1, "onehot80");
      v = '0; v[i*W +: W] = W'(i * 37 + 5); run(v, 1'b0, "onehot_mix");
    end

    // R8 wrap cases
    run({N{1'b1}}, 1'b0, "R8 all ones");
    v = '0; for (int i = 0; i < L; i++) v[i*W +: W] = 8'h80; run(v, 1'b1, "R8 all 80");
    run('0, 1'b1, "zeros");

    // pseudo-random sweep, poke while busy on odd runs (R3)
    lf = 64'h1234_5678_9abc_def1;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[N-2:0], lf[N-1] ^ lf[N-2] ^ lf[N-4] ^ lf[N-5]} ^ N'(k);
      run(lf, k[0], "sweep");
    end

    // R7 idle stability over several cycles
    v = total_vec(lf);
    repeat (5) @(negedge clk);
    check(out_data == v && out_valid == 1'b0, "R7 long idle", out_data, v);

    // R9 back-to-back: accept in the done cycle
    v = 64'h0102_0304_0506_0708;
    in_valid = 1'b1; in_data = v;
    @(negedge clk);
    finish_run(v, 1'b0, "R9 first");
    lf = 64'hf0e0_d0c0_b0a0_9080;
    in_valid = 1'b1; in_data = lf;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 no second done", N'(out_valid), '0);
    finish_run(lf, 1'b0, "R9 second");
    in_valid = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule